// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block lets a host reach the configuration registers of devices behind a PCI host bridge through two 32-bit windows on a simple memory-mapped bus. The first window holds a selector register. It names a bus, a device/function pair and a register offset, and its top bit arms the data window. The second window is a data port. Byte, halfword and word accesses to it are turned into single configuration requests on a valid/ready request port. A read completes when the response comes back.

Each data-port access is screened before anything goes downstream. The selector must be armed. The addressed target must be present and powered. A hot-added non-zero function must have its function 0 alongside it. The effective register offset must lie below the configuration-space limit. A read that fails any of these returns all ones, and a write that fails is dropped. An access that passes is shortened so that it never extends past the limit. Read data is placed into the host byte lanes that the access offset selects.

Top module: `cfgb_bridge`

## Requirements
- R1: After reset the selector register reads as 0x00000000, so the data window is disarmed.
- R2: The selector register is written only by a write to window 0 at byte offset 0 with length 4. Any other write to that window leaves the stored value unchanged.
- R3: A read of window 0 returns all 32 stored selector bits unchanged.
- R4: While selector bit 31 is 0, data-window reads return 0xFFFFFFFF and data-window writes issue no downstream request.
- R5: A forwarded request carries bus = selector bits 23:16 and device/function = selector bits 15:8. Its register offset is selector bits 7:0 ORed with the low two bits of the data-window access offset.
- R6: If the target is absent, is unpowered, or is a hot-added function with a non-zero function number (devfn bits 2:0) whose function 0 is absent, reads return 0xFFFFFFFF and writes issue no request.
- R7: If the effective register offset is greater than or equal to LIMIT, reads return 0xFFFFFFFF and writes issue no request.
- R8: The forwarded length in bytes is the smaller of the host length (1, 2 or 4) and LIMIT minus the effective offset.
- R9: Read data is taken from the low forwarded-length bytes of the response, with the other bytes zero, and shifted up by 8 times the access offset. Write data is forwarded as the host write data shifted down by 8 times the access offset.
- R10: A pending request holds its valid and its fields stable until it is accepted. A data read is not acknowledged to the host before the response arrives.
- R11: The host acknowledge is a single-cycle pulse for every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access request, held until h_ready |
| h_we | input | 1 | 1 = write, 0 = read |
| h_win | input | 1 | 0 = selector window, 1 = data window |
| h_off | input | 2 | Byte offset inside the window |
| h_len | input | 3 | Access length in bytes (1, 2 or 4) |
| h_wdata | input | 32 | Host write data, lane aligned |
| h_ready | output | 1 | One-cycle access completion |
| h_rdata | output | 32 | Read data, valid with h_ready |
| probe_bus | output | 8 | Bus number being looked up |
| probe_devfn | output | 8 | Device/function being looked up |
| probe_present | input | 1 | Target exists |
| probe_powered | input | 1 | Target has power |
| probe_hotadd | input | 1 | Target was hot-added |
| probe_fn0 | input | 1 | Function 0 of the same device exists |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Configuration request accepted |
| req_we | output | 1 | Request is a write |
| req_bus | output | 8 | Request bus number |
| req_devfn | output | 8 | Request device/function |
| req_off | output | 8 | Request register offset |
| req_len | output | 3 | Request length in bytes |
| req_wdata | output | 32 | Right-aligned write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Right-aligned read response data |

## Verification
The assertions assume a host that holds h_req and its fields steady until h_ready, and that drops h_req in the cycle it sees h_ready. They also assume a responder that raises rsp_valid only once per accepted read, and probe inputs that are a pure function of probe_bus and probe_devfn. The bench drives each host access from a task that waits for h_ready before it releases the request. Its downstream model answers from a lookup on the probe outputs, accepts requests after a varying stall and returns exactly one response per read, so every stimulus stays inside those assumptions.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } cfgb_state_t;

  localparam int unsigned DW = 32;
  localparam int unsigned FW = 8;
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data;
  end

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/cfgb_qualify.sv
module cfgb_qualify #(
  parameter int unsigned LIMIT = 256,
  parameter int unsigned FW    = 8
) (
  input  logic          armed,
  input  logic [FW-1:0] sel_off,
  input  logic [FW-1:0] sel_devfn,
  input  logic [1:0]    acc_off,
  input  logic [2:0]    acc_len,
  input  logic          present,
  input  logic          powered,
  input  logic          hotadd,
  input  logic          fn0,
  output logic [FW-1:0] eff_off,
  output logic [2:0]    fwd_len,
  output logic          accept
);
  localparam int unsigned RW = FW + 1;
  localparam logic [RW-1:0] LIM = RW'(LIMIT);

  logic [RW-1:0] remain;
  logic          visible;
  logic          in_range;

  always_comb begin
    eff_off  = sel_off | FW'(acc_off);
    in_range = {1'b0, eff_off} < LIM;
    remain   = LIM - {1'b0, eff_off};
    fwd_len  = (remain < RW'(acc_len)) ? remain[2:0] : acc_len;
    visible  = present && powered && !(hotadd && (sel_devfn[2:0] != 3'd0) && !fn0);
    accept   = armed && visible && in_range;
  end
endmodule

// File: rtl/cfgb_lanes.sv
module cfgb_lanes #(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    rd_off,
  input  logic [2:0]    rd_len,
  input  logic [DW-1:0] rsp_data,
  input  logic [1:0]    wr_off,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_placed,
  output logic [DW-1:0] wr_aligned
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] masked;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign masked[8*b +: 8] = (b < int'(rd_len)) ? rsp_data[8*b +: 8] : 8'h00;
  end

  assign rd_placed  = masked << {rd_off, 3'b000};
  assign wr_aligned = wr_data >> {wr_off, 3'b000};
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_req,
  input  logic          h_we,
  input  logic          h_win,
  input  logic [1:0]    h_off,
  input  logic [2:0]    h_len,
  input  logic [31:0]   h_wdata,
  output logic          h_ready,
  output logic [31:0]   h_rdata,
  output logic [7:0]    probe_bus,
  output logic [7:0]    probe_devfn,
  input  logic          probe_present,
  input  logic          probe_powered,
  input  logic          probe_hotadd,
  input  logic          probe_fn0,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [7:0]    req_bus,
  output logic [7:0]    req_devfn,
  output logic [7:0]    req_off,
  output logic [2:0]    req_len,
  output logic [31:0]   req_wdata,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data
);
  cfgb_state_t st;
  logic [DW-1:0] sel;
  logic          sel_wr;
  logic [FW-1:0] eff_off;
  logic [2:0]    fwd_len;
  logic          accept;
  logic [1:0]    off_q;
  logic [DW-1:0] rd_placed;
  logic [DW-1:0] wr_aligned;

  assign sel_wr = (st == ST_IDLE) && h_req && !h_win && h_we &&
                  (h_off == 2'd0) && (h_len == 3'd4);

  cfgb_addr_reg #(.W(DW)) u_sel (
    .clk(clk), .rst(rst), .wr_en(sel_wr), .wr_data(h_wdata), .q(sel)
  );

  assign probe_bus   = sel[23:16];
  assign probe_devfn = sel[15:8];

  cfgb_qualify #(.LIMIT(LIMIT), .FW(FW)) u_qual (
    .armed(sel[31]), .sel_off(sel[7:0]), .sel_devfn(sel[15:8]),
    .acc_off(h_off), .acc_len(h_len),
    .present(probe_present), .powered(probe_powered),
    .hotadd(probe_hotadd), .fn0(probe_fn0),
    .eff_off(eff_off), .fwd_len(fwd_len), .accept(accept)
  );

  cfgb_lanes #(.DW(DW)) u_lanes (
    .rd_off(off_q), .rd_len(req_len), .rsp_data(rsp_data),
    .wr_off(h_off), .wr_data(h_wdata),
    .rd_placed(rd_placed), .wr_aligned(wr_aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      h_ready   <= 1'b0;
      h_rdata   <= '0;
      req_valid <= 1'b0;
      req_we    <= 1'b0;
      req_bus   <= '0;
      req_devfn <= '0;
      req_off   <= '0;
      req_len   <= '0;
      req_wdata <= '0;
      off_q     <= '0;
    end else begin
      h_ready <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (h_req) begin
            if (!h_win) begin
              if (!h_we) h_rdata <= sel;
              h_ready <= 1'b1;
              st      <= ST_ACK;
            end else if (accept) begin
              req_valid <= 1'b1;
              req_we    <= h_we;
              req_bus   <= sel[23:16];
              req_devfn <= sel[15:8];
              req_off   <= eff_off;
              req_len   <= fwd_len;
              req_wdata <= wr_aligned;
              off_q     <= h_off;
              st        <= ST_REQ;
            end else begin
              if (!h_we) h_rdata <= '1;
              h_ready <= 1'b1;
              st      <= ST_ACK;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            if (req_we) begin
              h_ready <= 1'b1;
              st      <= ST_ACK;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            h_rdata <= rd_placed;
            h_ready <= 1'b1;
            st      <= ST_ACK;
          end
        end
        ST_ACK: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  armed_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> sel[31]);

  // R7
  limit_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((9'(req_off) + 9'(req_len)) <= 9'(LIMIT)) && (req_len != 3'd0));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid &&
      $stable({req_we, req_bus, req_devfn, req_off, req_len, req_wdata}));

  // R10
  rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !rsp_valid) |=> !h_ready);

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    h_ready |=> !h_ready);
endmodule

// File: tb/sim_cfgb_bridge.sv
module sim_cfgb_bridge;
  localparam int unsigned LIM = 192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 1'b0, h_we = 1'b0, h_win = 1'b0;
  logic [1:0]  h_off = '0;
  logic [2:0]  h_len = 3'd4;
  logic [31:0] h_wdata = '0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic [7:0]  probe_bus, probe_devfn;
  logic        probe_present, probe_powered, probe_hotadd, probe_fn0;
  logic        req_valid, req_we;
  logic        req_ready = 1'b0;
  logic [7:0]  req_bus, req_devfn, req_off;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;

  int checks = 0, errors = 0;
  int req_cnt = 0;
  int stall = 0;
  bit pend_rd = 0;
  bit finished = 0;
  logic [7:0]  cap_bus, cap_devfn, cap_off;
  logic [2:0]  cap_len;
  logic        cap_we;
  logic [31:0] cap_wdata;

  always #5 clk = ~clk;

  cfgb_bridge #(.LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_win(h_win),
    .h_off(h_off), .h_len(h_len), .h_wdata(h_wdata),
    .h_ready(h_ready), .h_rdata(h_rdata),
    .probe_bus(probe_bus), .probe_devfn(probe_devfn),
    .probe_present(probe_present), .probe_powered(probe_powered),
    .probe_hotadd(probe_hotadd), .probe_fn0(probe_fn0),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
    .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic bit t_present(input logic [7:0] b, input logic [7:0] df);
    return (b < 8'd2) && (df[7:3] < 5'd4) && !(df[7:3] == 5'd2 && df[2:0] == 3'd0);
  endfunction
  function automatic bit t_powered(input logic [7:0] b, input logic [7:0] df);
    return !(b == 8'd1 && df[7:3] == 5'd3);
  endfunction
  function automatic bit t_hotadd(input logic [7:0] df);
    return df[7:3] == 5'd2;
  endfunction
  function automatic logic [31:0] pat(input logic [7:0] b, input logic [7:0] df,
                                      input logic [7:0] o);
    return {b ^ 8'h5A, df, o, 8'hC3};
  endfunction

  always_comb begin
    probe_present = t_present(probe_bus, probe_devfn);
    probe_powered = t_powered(probe_bus, probe_devfn);
    probe_hotadd  = t_hotadd(probe_devfn);
    probe_fn0     = t_present(probe_bus, {probe_devfn[7:3], 3'b000});
  end

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend_rd) begin
        rsp_valid = 1'b1;
        rsp_data  = pat(cap_bus, cap_devfn, cap_off);
        pend_rd   = 0;
      end
      if (req_ready) begin
        req_ready = 1'b0;
      end else if (req_valid) begin
        if (stall > 0) begin
          stall--;
        end else begin
          req_ready = 1'b1;
          cap_bus = req_bus; cap_devfn = req_devfn; cap_off = req_off;
          cap_len = req_len; cap_we = req_we; cap_wdata = req_wdata;
          req_cnt++;
          if (!req_we) pend_rd = 1;
          stall = req_cnt % 3;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic win, input logic we, input logic [1:0] off,
                     input logic [2:0] len, input logic [31:0] wd,
                     output logic [31:0] rd);
    @(negedge clk);
    h_req = 1'b1; h_win = win; h_we = we; h_off = off; h_len = len; h_wdata = wd;
    do @(negedge clk); while (!h_ready);
    rd = h_rdata;
    h_req = 1'b0;
  endtask

  task automatic data_case(input logic [31:0] selv, input logic [1:0] off,
                           input logic [2:0] len);
    logic [31:0] rd, wd, exp_rd, mask;
    logic [7:0] b, df, eo;
    int n0, rem;
    logic [2:0] el;
    bit vis, ok;
    b = selv[23:16]; df = selv[15:8];
    eo = selv[7:0] | {6'b0, off};
    vis = t_present(b, df) && t_powered(b, df) &&
          !(t_hotadd(df) && df[2:0] != 3'd0 && !t_present(b, {df[7:3], 3'b000}));
    ok = selv[31] && vis && (int'(eo) < LIM);
    rem = LIM - int'(eo);
    el = (rem < int'(len)) ? 3'(rem) : len;
    mask = '0;
    for (int i = 0; i < 4; i++) if (i < int'(el)) mask[8*i +: 8] = 8'hFF;
    exp_rd = (pat(b, df, eo) & mask) << (8 * int'(off));
    // read
    n0 = req_cnt;
    acc(1'b1, 1'b0, off, len, 32'h0, rd);
    if (ok) begin
      chk("R9 read lanes", rd, exp_rd);
      chk("R5 read fields", {cap_we, cap_bus, cap_devfn, cap_off}, {1'b0, b, df, eo});
      chk("R8 read length", cap_len, el);
      chk("R10 one request", req_cnt, n0 + 1);
    end else begin
      if (!selv[31])   chk("R4 disarmed read", rd, 32'hFFFF_FFFF);
      else if (!vis)   chk("R6 absent read", rd, 32'hFFFF_FFFF);
      else             chk("R7 over limit read", rd, 32'hFFFF_FFFF);
      chk("R6 R7 no read request", req_cnt, n0);
    end
    // write
    wd = {df, eo, b, 8'h96} ^ 32'h1357_9BDF;
    n0 = req_cnt;
    acc(1'b1, 1'b1, off, len, wd, rd);
    if (ok) begin
      chk("R9 write data", cap_wdata, wd >> (8 * int'(off)));
      chk("R5 write fields", {cap_we, cap_bus, cap_devfn, cap_off, cap_len},
          {1'b1, b, df, eo, el});
      chk("R10 one write request", req_cnt, n0 + 1);
    end else if (!selv[31]) begin
      chk("R4 disarmed write dropped", req_cnt, n0);
    end else if (!vis) begin
      chk("R6 absent write dropped", req_cnt, n0);
    end else begin
      chk("R7 over limit write dropped", req_cnt, n0);
    end
  endtask

  task automatic sweep_offs(input logic [31:0] selv);
    data_case(selv, 2'd0, 3'd4);
    data_case(selv, 2'd0, 3'd2);
    data_case(selv, 2'd2, 3'd2);
    for (int o = 0; o < 4; o++) data_case(selv, 2'(o), 3'd1);
  endtask

  initial begin
    logic [31:0] rd, selv;
    logic [7:0] roffs [7];
    roffs = '{8'h00, 8'h10, 8'hBC, 8'hBD, 8'hBE, 8'hC0, 8'hFC};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset value and disarmed window
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd);
    chk("R1 selector after reset", rd, 32'h0);
    acc(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd);
    chk("R1 R4 data read after reset", rd, 32'hFFFF_FFFF);
    chk("R4 no request after reset", req_cnt, 0);
    // R2 / R3: selector write qualification
    acc(1'b0, 1'b1, 2'd0, 3'd4, 32'hA5C3_0F81, rd);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd);
    chk("R3 selector readback", rd, 32'hA5C3_0F81);
    acc(1'b0, 1'b1, 2'd0, 3'd2, 32'h1111_1111, rd);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd);
    chk("R2 short write ignored", rd, 32'hA5C3_0F81);
    acc(1'b0, 1'b1, 2'd2, 3'd4, 32'h2222_2222, rd);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd);
    chk("R2 offset write ignored", rd, 32'hA5C3_0F81);
    acc(1'b0, 1'b1, 2'd0, 3'd1, 32'h3333_3333, rd);
    acc(1'b0, 1'b0, 2'd2, 3'd4, 32'h0, rd);
    chk("R2 R3 byte write ignored", rd, 32'hA5C3_0F81);
    // disarmed sweep (R4)
    for (int d = 0; d < 4; d++) begin
      selv = {1'b0, 7'h2A, 8'd0, 5'(d), 3'd0, 8'h10};
      acc(1'b0, 1'b1, 2'd0, 3'd4, selv, rd);
      sweep_offs(selv);
    end
    // armed sweep (R5..R11)
    for (int b = 0; b < 3; b++)
      for (int d = 0; d < 5; d++)
        for (int f = 0; f < 2; f++)
          for (int r = 0; r < 7; r++) begin
            selv = {1'b1, 7'h15, 8'(b), 5'(d), 3'(f), roffs[r]};
            acc(1'b0, 1'b1, 2'd0, 3'd4, selv, rd);
            acc(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd);
            chk("R3 armed selector readback", rd, selv);
            sweep_offs(selv);
          end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule